// File: doc/BRIEF.md
# Page-Selective Invalidation Address Matcher

This block decides which cached address-translation entries must be dropped when software asks for a page-selective invalidation. Software first loads an invalidation register with a page number, an address mask and a hint. It then issues a command pulse that names a translation engine and a domain. There is one register copy for each engine.

When a command is accepted, the block takes a snapshot of the chosen engine's register. It then walks the cache once, presenting an entry index on every cycle. The cache returns that entry's valid bit, leaf flag, domain ID and page number. The block answers with a registered flush decision for each index.

A leaf entry is flushed when it is valid, belongs to the command's domain, and its page number matches the register page with the low mask bits ignored. The hint selects what happens to non-leaf entries. With the hint clear, every valid non-leaf entry of the domain is flushed. With the hint set, all non-leaf entries are kept. A mask value outside the supported range does not start a walk: the block reports an error and flushes nothing.

Top module: `psi_inval_matcher`

## Requirements
- R1: After a synchronous reset, busy, done, mask_err, flush_vld and flush are 0. Every engine register holds page 0, mask 0 and hint 0.
- R2: A write with wr_en high loads the register of engine wr_eng: the page from wr_data[63:12], the hint from wr_data[6] and the mask from wr_data[5:0]. The registers of the other engines keep their values. A command uses the register of engine cmd_eng.
- R3: cmd_valid is taken only while busy is 0. After acceptance with a legal mask, busy is 1 for exactly NUM_ENT cycles, starting the cycle after acceptance. done is high for one cycle: the last busy cycle's successor. A cmd_valid seen while busy is 1 is ignored.
- R4: The page, mask, hint and domain are captured when the command is accepted. A register write during a walk has no effect on that walk's decisions.
- R5: In the k-th busy cycle, ent_idx equals k (counting from 0). The decision for that entry appears in the next cycle with flush_vld set to 1 and flush_idx equal to k.
- R6: A valid leaf entry (ent_leaf = 1) of the command's domain is flushed when its page equals the register page after the low M bits of both are cleared. M is the mask, and each value from 0 to 9 is legal.
- R7: With the hint at 0, every valid non-leaf entry (ent_leaf = 0) of the command's domain is flushed, whatever its page number.
- R8: With the hint at 1, non-leaf entries are never flushed.
- R9: A mask above 9 starts no walk. In the cycle after acceptance, done and mask_err are both 1, and flush_vld stays 0.
- R10: An entry that is not valid, or whose domain differs from cmd_dom, is never flushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_eng | input | ENG_W | Engine whose register is written |
| wr_data | input | 64 | Register write value (page, hint, mask) |
| cmd_valid | input | 1 | Page-selective invalidate command |
| cmd_eng | input | ENG_W | Engine whose register the command uses |
| cmd_dom | input | DOM_W | Domain of the command |
| busy | output | 1 | Walk over the cache in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| mask_err | output | 1 | Command rejected because the mask is above 9 (valid with done) |
| ent_idx | output | IDX_W | Entry index being looked up |
| ent_valid | input | 1 | Looked-up entry is valid |
| ent_leaf | input | 1 | Looked-up entry is a leaf entry |
| ent_dom | input | DOM_W | Domain ID of the looked-up entry |
| ent_page | input | 52 | Page number of the looked-up entry |
| flush_vld | output | 1 | flush and flush_idx carry a decision |
| flush_idx | output | IDX_W | Entry index the decision belongs to |
| flush | output | 1 | Flush the entry at flush_idx |

## Verification
Take the clock edge that accepts a command as edge 0. The decision for entry k is due after edge k+1, and done is due after edge NUM_ENT. For a rejected mask, done and mask_err are both due after edge 0. busy must be low again after edge NUM_ENT+1. The bench drives every input at the falling edge and samples at the falling edge after each of these rising edges. It numbers each sample from the accepting edge and compares it with the cycle at which that result is due. It also rebuilds the expected flush set for each entry from the page, mask, hint and domain it wrote.

// File: rtl/psi_pkg.sv
package psi_pkg;
  parameter int PAGE_W = 52;
  parameter int MASK_W = 6;

  typedef struct packed {
    logic [PAGE_W-1:0] page;
    logic              hint;
    logic [MASK_W-1:0] mask;
  } inv_reg_t;
endpackage

// File: rtl/psi_addr_regs.sv
module psi_addr_regs
  import psi_pkg::*;
#(
  parameter int NUM_ENG = 2,
  parameter int ENG_W   = (NUM_ENG > 1) ? $clog2(NUM_ENG) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [ENG_W-1:0] wr_eng,
  input  logic [63:0]      wr_data,
  output inv_reg_t         regs_o [NUM_ENG]
);
  inv_reg_t q [NUM_ENG];
  logic unused_rsvd;
  assign unused_rsvd = ^wr_data[11:7];

  always_ff @(posedge clk) begin
    for (int e = 0; e < NUM_ENG; e++) begin
      if (rst) begin
        q[e] <= '0;
      end else if (wr_en && (int'(wr_eng) == e)) begin
        q[e].page <= wr_data[63:12];
        q[e].hint <= wr_data[6];
        q[e].mask <= wr_data[5:0];
      end
    end
  end

  for (genvar g = 0; g < NUM_ENG; g++) begin : g_eng
    assign regs_o[g] = q[g];
    // R2: a write to one engine leaves every other copy untouched
    p_other_copy_kept_r2: assert property (@(posedge clk) disable iff (rst)
      (wr_en && (int'(wr_eng) != g)) |=> $stable(q[g]));
  end
endmodule

// File: rtl/psi_sweep_ctrl.sv
module psi_sweep_ctrl
  import psi_pkg::*;
#(
  parameter int NUM_ENT  = 16,
  parameter int DOM_W    = 16,
  parameter int MAX_MASK = 9,
  parameter int IDX_W    = $clog2(NUM_ENT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  inv_reg_t         cur_reg,
  input  logic [DOM_W-1:0] cmd_dom,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [IDX_W-1:0] idx,
  output inv_reg_t         work,
  output logic [DOM_W-1:0] work_dom
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_ENT - 1);

  logic accept, bad_mask;
  assign accept   = cmd_valid && !busy;
  assign bad_mask = int'(cur_reg.mask) > MAX_MASK;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      idx      <= '0;
      work     <= '0;
      work_dom <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (accept) begin
        if (bad_mask) begin
          done <= 1'b1;
          err  <= 1'b1;
        end else begin
          busy     <= 1'b1;
          idx      <= '0;
          work     <= cur_reg;
          work_dom <= cmd_dom;
        end
      end else if (busy) begin
        if (idx == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  // R3: a walk can only end through a done pulse
  p_walk_ends_done_r3: assert property (@(posedge clk) disable iff (rst)
    busy |=> (busy || done));
  // R3: a walk only starts from a command
  p_walk_from_cmd_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(cmd_valid));
  // R4: captured settings do not move while walking
  p_work_frozen_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(work) && $stable(work_dom)));
  // R9: an error is only reported together with done
  p_err_with_done_r9: assert property (@(posedge clk) disable iff (rst)
    err |-> (done && !busy));
endmodule

// File: rtl/psi_entry_cmp.sv
module psi_entry_cmp
  import psi_pkg::*;
#(
  parameter int DOM_W = 16
) (
  input  inv_reg_t          work,
  input  logic [DOM_W-1:0]  work_dom,
  input  logic              ent_valid,
  input  logic              ent_leaf,
  input  logic [DOM_W-1:0]  ent_dom,
  input  logic [PAGE_W-1:0] ent_page,
  output logic              hit
);
  logic [PAGE_W-1:0] keep;
  logic in_dom, page_eq;

  assign keep    = {PAGE_W{1'b1}} << work.mask;
  assign in_dom  = ent_valid && (ent_dom == work_dom);
  assign page_eq = ((ent_page ^ work.page) & keep) == '0;

  always_comb begin
    if (!in_dom)       hit = 1'b0;
    else if (ent_leaf) hit = page_eq;
    else               hit = !work.hint;
  end
endmodule

// File: rtl/psi_inval_matcher.sv
module psi_inval_matcher
  import psi_pkg::*;
#(
  parameter int NUM_ENG  = 2,
  parameter int NUM_ENT  = 16,
  parameter int DOM_W    = 16,
  parameter int MAX_MASK = 9,
  parameter int ENG_W    = (NUM_ENG > 1) ? $clog2(NUM_ENG) : 1,
  parameter int IDX_W    = $clog2(NUM_ENT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ENG_W-1:0]  wr_eng,
  input  logic [63:0]       wr_data,
  input  logic              cmd_valid,
  input  logic [ENG_W-1:0]  cmd_eng,
  input  logic [DOM_W-1:0]  cmd_dom,
  output logic              busy,
  output logic              done,
  output logic              mask_err,
  output logic [IDX_W-1:0]  ent_idx,
  input  logic              ent_valid,
  input  logic              ent_leaf,
  input  logic [DOM_W-1:0]  ent_dom,
  input  logic [PAGE_W-1:0] ent_page,
  output logic              flush_vld,
  output logic [IDX_W-1:0]  flush_idx,
  output logic              flush
);
  inv_reg_t         regs [NUM_ENG];
  inv_reg_t         work;
  logic [DOM_W-1:0] work_dom;
  logic             hit;

  psi_addr_regs #(.NUM_ENG(NUM_ENG), .ENG_W(ENG_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_eng(wr_eng),
    .wr_data(wr_data), .regs_o(regs)
  );

  psi_sweep_ctrl #(.NUM_ENT(NUM_ENT), .DOM_W(DOM_W), .MAX_MASK(MAX_MASK),
                   .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cur_reg(regs[cmd_eng]),
    .cmd_dom(cmd_dom), .busy(busy), .done(done), .err(mask_err),
    .idx(ent_idx), .work(work), .work_dom(work_dom)
  );

  psi_entry_cmp #(.DOM_W(DOM_W)) u_cmp (
    .work(work), .work_dom(work_dom), .ent_valid(ent_valid),
    .ent_leaf(ent_leaf), .ent_dom(ent_dom), .ent_page(ent_page), .hit(hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flush_vld <= 1'b0;
      flush_idx <= '0;
      flush     <= 1'b0;
    end else begin
      flush_vld <= busy;
      flush_idx <= ent_idx;
      flush     <= busy && hit;
    end
  end

  // R5: a flush decision always comes with its valid strobe
  p_flush_has_vld_r5: assert property (@(posedge clk) disable iff (rst)
    flush |-> flush_vld);
  // R9: a rejected mask produces no decisions
  p_err_no_flush_r9: assert property (@(posedge clk) disable iff (rst)
    mask_err |-> !flush_vld);
  // R10: only valid entries are flushed
  p_valid_only_r10: assert property (@(posedge clk) disable iff (rst)
    flush |-> $past(ent_valid));
  // R8: with the hint set, a non-leaf entry survives
  p_nonleaf_kept_r8: assert property (@(posedge clk) disable iff (rst)
    (flush && !$past(ent_leaf)) |-> !$past(work.hint));
endmodule

// File: tb/psi_inval_matcher_test.sv
module psi_inval_matcher_test;
  localparam int N = 16;
  localparam int DW = 16;
  localparam int PW = 52;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0, wr_eng = 1'b0, cmd_valid = 1'b0, cmd_eng = 1'b0;
  logic [63:0] wr_data = '0;
  logic [DW-1:0] cmd_dom = '0;
  logic busy, done, mask_err, flush_vld, flush;
  logic [3:0] ent_idx, flush_idx;

  logic          e_valid [N];
  logic          e_leaf  [N];
  logic [DW-1:0] e_dom   [N];
  logic [PW-1:0] e_page  [N];

  int tests = 0, fails = 0;
  logic seen [N];
  int vld_cnt, done_cnt, done_at, err_cnt, idx_bad;
  logic busy0, busy_end;

  always #5 clk = ~clk;

  psi_inval_matcher uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_eng(wr_eng), .wr_data(wr_data),
    .cmd_valid(cmd_valid), .cmd_eng(cmd_eng), .cmd_dom(cmd_dom),
    .busy(busy), .done(done), .mask_err(mask_err), .ent_idx(ent_idx),
    .ent_valid(e_valid[ent_idx]), .ent_leaf(e_leaf[ent_idx]),
    .ent_dom(e_dom[ent_idx]), .ent_page(e_page[ent_idx]),
    .flush_vld(flush_vld), .flush_idx(flush_idx), .flush(flush)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write_reg(input logic eng, input logic [PW-1:0] pg, input logic hint, input logic [5:0] m);
    @(negedge clk);
    wr_en = 1'b1; wr_eng = eng; wr_data = {pg, 5'b0, hint, m};
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Entries around a base page: entry k<15 flips page bit k, entry 15 is exact.
  // Non-leaf at 3, 7, 11; invalid at 6; foreign domain at 5 and 14.
  task automatic fill(input logic [PW-1:0] base, input logic [DW-1:0] d);
    for (int k = 0; k < N; k++) begin
      e_valid[k] = (k != 6);
      e_leaf[k]  = !(k == 3 || k == 7 || k == 11);
      e_dom[k]   = (k == 5 || k == 14) ? d + 16'd1 : d;
      e_page[k]  = (k == 15) ? base : base ^ (PW'(1) << k);
    end
  endtask

  // mode 0: plain; 1: rewrite register mid-walk; 2: hold cmd_valid mid-walk
  task automatic run_cmd(input logic eng, input logic [DW-1:0] d, input int mode);
    vld_cnt = 0; done_cnt = 0; done_at = -1; err_cnt = 0; idx_bad = 0;
    for (int k = 0; k < N; k++) seen[k] = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_eng = eng; cmd_dom = d;
    for (int i = 0; i <= N + 1; i++) begin
      @(negedge clk);
      if (i == 0) begin cmd_valid = 1'b0; busy0 = busy; end
      if (mode == 1 && i == 2) begin
        wr_en = 1'b1; wr_eng = eng; wr_data = {~e_page[15], 5'b0, 1'b1, 6'd0};
      end
      if (mode == 1 && i == 3) wr_en = 1'b0;
      if (mode == 2) cmd_valid = (i >= 2 && i <= N - 2);
      if (flush_vld) begin
        vld_cnt++;
        if (int'(flush_idx) != i - 1) idx_bad++;
        seen[flush_idx] = flush;
      end
      if (done) begin done_cnt++; done_at = i; end
      if (mask_err) err_cnt++;
      if (i == N + 1) busy_end = busy;
    end
    cmd_valid = 1'b0;
  endtask

  function automatic bit exp_flush(int k, logic [PW-1:0] pg, logic [5:0] m, logic hint, logic [DW-1:0] d);
    logic [PW-1:0] keep;
    keep = {PW{1'b1}} << m;
    if (!e_valid[k] || e_dom[k] != d) return 1'b0;
    if (e_leaf[k]) return ((e_page[k] ^ pg) & keep) == '0;
    return !hint;
  endfunction

  task automatic check_walk(input string name, input logic [PW-1:0] pg, input logic [5:0] m,
                            input logic hint, input logic [DW-1:0] d);
    check(busy0 == 1'b1, {name, " R3 busy after accept"}, busy0, 1);
    check(busy_end == 1'b0, {name, " R3 idle after walk"}, busy_end, 0);
    check(done_cnt == 1 && done_at == N, {name, " R3 done timing"}, done_at, N);
    check(vld_cnt == N && idx_bad == 0, {name, " R5 decision order"}, vld_cnt, N);
    check(err_cnt == 0, {name, " R9 no error"}, err_cnt, 0);
    for (int k = 0; k < N; k++) begin
      string tag;
      bit ex;
      ex = exp_flush(k, pg, m, hint, d);
      if (!e_valid[k] || e_dom[k] != d) tag = " R10";
      else if (e_leaf[k]) tag = " R6";
      else tag = hint ? " R8" : " R7";
      check(seen[k] == ex, $sformatf("%s%s entry %0d", name, tag, k), seen[k], ex);
    end
  endtask

  task automatic t_reset;
    check(!busy && !done && !mask_err && !flush_vld && !flush, "R1 outputs after reset",
          {busy, done, mask_err, flush_vld, flush}, 0);
    fill('0, '0);
    run_cmd(1'b0, '0, 0);
    check_walk("R1 zero register", '0, 6'd0, 1'b0, '0);
  endtask

  task automatic t_masks;
    logic [PW-1:0] base;
    base = 52'h0_1234_5678_9000;
    fill(base, 16'h0042);
    write_reg(1'b0, base, 1'b1, 6'd0);
    run_cmd(1'b0, 16'h0042, 0);
    check_walk("mask0 hint1", base, 6'd0, 1'b1, 16'h0042);
    write_reg(1'b0, base, 1'b1, 6'd4);
    run_cmd(1'b0, 16'h0042, 0);
    check_walk("mask4 hint1", base, 6'd4, 1'b1, 16'h0042);
    write_reg(1'b0, base ^ 52'h1ff, 1'b0, 6'd9);
    run_cmd(1'b0, 16'h0042, 0);
    check_walk("mask9 hint0", base ^ 52'h1ff, 6'd9, 1'b0, 16'h0042);
  endtask

  task automatic t_bad_mask(input logic [5:0] m);
    write_reg(1'b0, '0, 1'b0, m);
    run_cmd(1'b0, 16'h0042, 0);
    check(done_cnt == 1 && done_at == 0, $sformatf("R9 mask %0d done next cycle", m), done_at, 0);
    check(err_cnt == 1, $sformatf("R9 mask %0d error flag", m), err_cnt, 1);
    check(vld_cnt == 0 && busy0 == 1'b0, $sformatf("R9 mask %0d no walk", m), vld_cnt, 0);
  endtask

  task automatic t_engines;
    logic [PW-1:0] pa, pb;
    pa = 52'h0_0000_0abc_0000;
    pb = 52'h0_0777_0000_0400;
    write_reg(1'b0, pa, 1'b1, 6'd2);
    write_reg(1'b1, pb, 1'b0, 6'd3);
    fill(pb, 16'h0009);
    run_cmd(1'b1, 16'h0009, 0);
    check_walk("R2 engine1", pb, 6'd3, 1'b0, 16'h0009);
    fill(pa, 16'h0009);
    run_cmd(1'b0, 16'h0009, 0);
    check_walk("R2 engine0 kept", pa, 6'd2, 1'b1, 16'h0009);
  endtask

  task automatic t_snapshot;
    logic [PW-1:0] p;
    p = 52'h0_0000_0000_5550;
    write_reg(1'b0, p, 1'b0, 6'd1);
    fill(p, 16'h0100);
    run_cmd(1'b0, 16'h0100, 1);
    check_walk("R4 write mid-walk", p, 6'd1, 1'b0, 16'h0100);
    fill(~p, 16'h0100);
    run_cmd(1'b0, 16'h0100, 0);
    check_walk("R2 new value used next", ~p, 6'd0, 1'b1, 16'h0100);
  endtask

  task automatic t_busy_cmd;
    logic [PW-1:0] p;
    p = 52'h0_0000_0000_0ff0;
    write_reg(1'b0, p, 1'b1, 6'd5);
    fill(p, 16'h0003);
    run_cmd(1'b0, 16'h0003, 2);
    check_walk("R3 cmd while busy", p, 6'd5, 1'b1, 16'h0003);
  endtask

  initial begin
    fill('0, '0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_masks();
    t_bad_mask(6'd10);
    t_bad_mask(6'd63);
    t_engines();
    t_snapshot();
    t_busy_cmd();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule